// File: doc/BRIEF.md
# Paged I/O Window Decoder

This block sits inside a bus bridge and decides which way an I/O cycle travels. It keeps two address windows. Each window is described by a base register and a limit register, and software reaches both through a 32-bit configuration port addressed by dword index. Every incoming 32-bit I/O address is compared against both windows in the same cycle.

The window's 64-Kbyte page comes from the upper half of its base register. The limit register supplies only the dword-granular top offset inside that page, and its two lowest bits are taken as ones when the compare is made. A window takes part in decoding only while its base or its limit holds a nonzero value. A cycle from the upstream side that lands in a live window is forwarded downstream. A cycle from the downstream side that lands in no window is forwarded upstream.

Top module: `iowin_decoder`

## Requirements
- R1: After reset all four window registers read 00000000h, and no window matches any address.
- R2: Dword indices 0Bh and 0Dh select the base registers of window 0 and window 1. Dword indices 0Ch and 0Eh select the limit registers of window 0 and window 1. Any other index reads zero, and a write to it changes no register.
- R3: Base register bits 31 to 2 are writable. Base bits 1 and 0 always read zero.
- R4: Limit register bits 15 to 2 are writable. Limit bits 31 to 16 and bits 1 and 0 always read zero, and writes to them have no effect.
- R5: Byte-enable bit k gates register bits 8k+7 down to 8k on a write. Disabled bytes keep their value.
- R6: `cfg_rdata` shows the masked value of the register selected by `cfg_dw` in the same cycle. A write becomes visible from the clock edge on which it is taken.
- R7: A window is live only while its base or its limit is nonzero. A window whose base and limit are both zero never matches.
- R8: A live window matches an address A when {base[31:2],2'b00} <= A <= {base[31:16],limit[15:2],2'b11}. `win_hit[w]` reports this for window w, whatever the values of `io_valid` and `io_src_down`.
- R9: A window whose limit offset (bits 15 to 2) lies below its base offset matches no address.
- R10: `fwd_down` is high when `io_valid` is high, `io_src_down` is low and either window matches. `fwd_up` is high when `io_valid` is high, `io_src_down` is high and no window matches. Both outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dw | input | 6 | Configuration dword index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, same cycle |
| io_addr | input | 32 | I/O address under decode |
| io_valid | input | 1 | An I/O cycle is present |
| io_src_down | input | 1 | 1 when the cycle comes from the downstream side |
| win_hit | output | 2 | Per-window match flags |
| fwd_down | output | 1 | Forward the cycle downstream |
| fwd_up | output | 1 | Forward the cycle upstream |

## Verification
A corrupted register bit appears on `cfg_rdata` the first cycle its index is selected. It also appears on `win_hit` as soon as an address near the affected window edge is presented, because the compare is purely combinational. A wrong forwarding decision appears on `fwd_down` or `fwd_up` in the same cycle as the address. The bench therefore probes addresses one below, on, and one above each window bound, as well as in a neighbouring page. It reads every register back after each write.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 6;
  localparam int BE_W   = DATA_W / 8;

  localparam logic [DATA_W-1:0] BASE_WMASK  = 32'hFFFF_FFFC;
  localparam logic [DATA_W-1:0] LIMIT_WMASK = 32'h0000_FFFC;

  localparam logic [OFF_W-1:0] BASE_IDX0  = 6'h0B;
  localparam logic [OFF_W-1:0] LIMIT_IDX0 = 6'h0C;
  localparam int               IDX_STRIDE = 2;

  function automatic logic [OFF_W-1:0] base_idx(input int w);
    return BASE_IDX0 + OFF_W'(IDX_STRIDE * w);
  endfunction

  function automatic logic [OFF_W-1:0] limit_idx(input int w);
    return LIMIT_IDX0 + OFF_W'(IDX_STRIDE * w);
  endfunction

  // Byte-lane merge of new data into a register, then clear read-only bits.
  function automatic logic [DATA_W-1:0] be_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] wdata,
    input logic [BE_W-1:0]   be,
    input logic [DATA_W-1:0] wmask
  );
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[b*8 +: 8] = wdata[b*8 +: 8];
    end
    return r & wmask;
  endfunction

  function automatic logic [DATA_W-1:0] win_lo(input logic [DATA_W-1:0] base);
    return {base[31:2], 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] win_hi(
    input logic [DATA_W-1:0] base,
    input logic [DATA_W-1:0] limit
  );
    return {base[31:16], limit[15:2], 2'b11};
  endfunction
endpackage

// File: rtl/iowin_regs.sv
module iowin_regs
  import iowin_pkg::*;
#(
  parameter int N_WIN = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [OFF_W-1:0]             cfg_dw,
  input  logic                         cfg_we,
  input  logic [BE_W-1:0]              cfg_be,
  input  logic [DATA_W-1:0]            cfg_wdata,
  output logic [DATA_W-1:0]            cfg_rdata,
  output logic [N_WIN-1:0][DATA_W-1:0] base_q,
  output logic [N_WIN-1:0][DATA_W-1:0] limit_q
);
  logic [N_WIN-1:0] base_wr;
  logic [N_WIN-1:0] limit_wr;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    assign base_wr[w]  = cfg_we && (cfg_dw == base_idx(w));
    assign limit_wr[w] = cfg_we && (cfg_dw == limit_idx(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[w]  <= '0;
        limit_q[w] <= '0;
      end else begin
        if (base_wr[w])  base_q[w]  <= be_merge(base_q[w], cfg_wdata, cfg_be, BASE_WMASK);
        if (limit_wr[w]) limit_q[w] <= be_merge(limit_q[w], cfg_wdata, cfg_be, LIMIT_WMASK);
      end
    end

    // R2: a register not addressed by a write keeps its value
    a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !base_wr[w] |=> $stable(base_q[w]));
    a_r2_limit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !limit_wr[w] |=> $stable(limit_q[w]));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < N_WIN; w++) begin
      if (cfg_dw == base_idx(w))  cfg_rdata = base_q[w];
      if (cfg_dw == limit_idx(w)) cfg_rdata = limit_q[w];
    end
  end
endmodule

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] limit,
  input  logic [DATA_W-1:0] addr,
  output logic              live,
  output logic              hit
);
  logic [DATA_W-1:0] lo;
  logic [DATA_W-1:0] hi;

  assign live = (|base) || (|limit);
  assign lo   = win_lo(base);
  assign hi   = win_hi(base, limit);
  assign hit  = live && (addr >= lo) && (addr <= hi);

  // R8: a match always lies in the page named by the base register
  a_r8_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (addr[31:16] == base[31:16]));
  // R7: a dead window never matches
  a_r7_dead_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !hit);
  // R9: an inverted window never matches
  a_r9_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (limit[15:2] < base[15:2]) |-> !hit);
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int N_WIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cfg_dw,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [31:0]       io_addr,
  input  logic              io_valid,
  input  logic              io_src_down,
  output logic [N_WIN-1:0]  win_hit,
  output logic              fwd_down,
  output logic              fwd_up
);
  logic [N_WIN-1:0][DATA_W-1:0] base_q;
  logic [N_WIN-1:0][DATA_W-1:0] limit_q;
  logic [N_WIN-1:0]             win_live;
  logic                         any_hit;

  iowin_regs #(.N_WIN(N_WIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_dw    (cfg_dw),
    .cfg_we    (cfg_we),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .base_q    (base_q),
    .limit_q   (limit_q)
  );

  for (genvar w = 0; w < N_WIN; w++) begin : g_match
    iowin_match u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .base  (base_q[w]),
      .limit (limit_q[w]),
      .addr  (io_addr),
      .live  (win_live[w]),
      .hit   (win_hit[w])
    );
  end

  assign any_hit  = |win_hit;
  assign fwd_down = io_valid && !io_src_down && any_hit;
  assign fwd_up   = io_valid && io_src_down && !any_hit;

  // R10: the two forwarding outputs are never asserted together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_down && fwd_up));
  // R10: an upstream forward only happens for a downstream-side cycle
  a_r10_up_dir: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_up |-> (io_src_down && win_hit == '0));
  // R4: the read-only limit bits read as zero
  a_r4_limit_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == limit_idx(0) || cfg_dw == limit_idx(1)) |->
      (cfg_rdata[31:16] == 16'h0 && cfg_rdata[1:0] == 2'b00));
  // R3: the base registers' low bits read as zero
  a_r3_base_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == base_idx(0) || cfg_dw == base_idx(1)) |-> (cfg_rdata[1:0] == 2'b00));
endmodule

// File: tb/iowin_decoder_bench.sv
module iowin_decoder_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] io_addr = '0;
  logic        io_valid = 1'b0;
  logic        io_src_down = 1'b0;
  logic [1:0]  win_hit;
  logic        fwd_down;
  logic        fwd_up;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_base [2];
  logic [31:0] m_lim  [2];

  always #(CLK_P/2) clk = ~clk;

  iowin_decoder u_iowin_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_dw(cfg_dw), .cfg_we(cfg_we), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .io_valid(io_valid), .io_src_down(io_src_down), .win_hit(win_hit),
    .fwd_down(fwd_down), .fwd_up(fwd_up)
  );

  function automatic logic [31:0] m_read(input logic [5:0] dw);
    case (dw)
      6'h0B: return m_base[0];
      6'h0C: return m_lim[0];
      6'h0D: return m_base[1];
      6'h0E: return m_lim[1];
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit m_hit(input int w, input logic [31:0] a);
    longint lo, hi, av;
    if (m_base[w] == 0 && m_lim[w] == 0) return 1'b0;
    lo = longint'(m_base[w]);
    hi = longint'(m_base[w] >> 16) * 65536 + longint'(m_lim[w] & 32'h0000_FFFC) + 3;
    av = longint'(a);
    return (av >= lo) && (av <= hi);
  endfunction

  function automatic logic [31:0] m_store(input logic [31:0] old_v, input logic [31:0] d,
                                          input logic [3:0] be, input logic [31:0] keep);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++) if (be[b]) r = (r & ~(32'hFF << (8*b))) | (d & (32'hFF << (8*b)));
    return r & keep;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [5:0] dw, input logic we, input logic [3:0] be,
                      input logic [31:0] wd, input logic [31:0] a, input logic v, input logic sd);
    logic [1:0] eh;
    cfg_dw = dw; cfg_we = we; cfg_be = be; cfg_wdata = wd;
    io_addr = a; io_valid = v; io_src_down = sd;
    #(CLK_P/4);
    eh = {m_hit(1, a), m_hit(0, a)};
    check(tag, "cfg_rdata", cfg_rdata, m_read(dw));
    check(tag, "win_hit", {30'h0, win_hit}, {30'h0, eh});
    check(tag, "fwd_down", {31'h0, fwd_down}, {31'h0, v && !sd && (eh != 0)});
    check(tag, "fwd_up", {31'h0, fwd_up}, {31'h0, v && sd && (eh == 0)});
    @(posedge clk);
    if (we) begin
      case (dw)
        6'h0B: m_base[0] = m_store(m_base[0], wd, be, 32'hFFFF_FFFC);
        6'h0C: m_lim[0]  = m_store(m_lim[0],  wd, be, 32'h0000_FFFC);
        6'h0D: m_base[1] = m_store(m_base[1], wd, be, 32'hFFFF_FFFC);
        6'h0E: m_lim[1]  = m_store(m_lim[1],  wd, be, 32'h0000_FFFC);
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [5:0] dw);
    step(tag, dw, 1'b0, 4'h0, 32'h0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    step(tag, dw, 1'b1, be, d, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic v, input logic sd);
    step(tag, 6'h00, 1'b0, 4'h0, 32'h0, a, v, sd);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 2; w++) begin m_base[w] = 0; m_lim[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values and no matches
    rd("R1", 6'h0B); rd("R1", 6'h0C); rd("R1", 6'h0D); rd("R1", 6'h0E);
    probe("R1", 32'h0000_0000, 1'b1, 1'b0);
    probe("R1", 32'h0000_0000, 1'b1, 1'b1);
    // R3: base writable bits
    wr("R3", 6'h0B, 4'hF, 32'h1234_5679);
    rd("R3", 6'h0B);
    // R4: limit writable bits
    wr("R4", 6'h0C, 4'hF, 32'hFFFF_FFFF);
    rd("R4", 6'h0C);
    // R5: byte lane gating
    wr("R5", 6'h0C, 4'h1, 32'h0000_0000);
    rd("R5", 6'h0C);
    wr("R5", 6'h0C, 4'h2, 32'hAAAA_56AA);
    rd("R5", 6'h0C);
    wr("R5", 6'h0C, 4'h1, 32'h5555_5580);
    rd("R6", 6'h0C);
    // R8: bounds of window 0 = 12345678h..12345683h
    probe("R8", 32'h1234_5677, 1'b1, 1'b0);
    probe("R8", 32'h1234_5678, 1'b1, 1'b0);
    probe("R8", 32'h1234_5683, 1'b1, 1'b0);
    probe("R8", 32'h1234_5684, 1'b1, 1'b0);
    probe("R8", 32'h1235_5678, 1'b1, 1'b0);
    probe("R8", 32'h1234_5680, 1'b0, 1'b0);
    // R10: forwarding direction
    probe("R10", 32'h1234_5680, 1'b1, 1'b1);
    probe("R10", 32'h1234_5690, 1'b1, 1'b1);
    probe("R10", 32'h1234_5690, 1'b0, 1'b1);
    // R2: unmapped index
    wr("R2", 6'h0F, 4'hF, 32'hFFFF_FFFF);
    rd("R2", 6'h0F); rd("R2", 6'h0B); rd("R2", 6'h0C); rd("R2", 6'h0D); rd("R2", 6'h0E);
    wr("R2", 6'h0A, 4'hF, 32'hDEAD_BEEF);
    rd("R2", 6'h0A); rd("R2", 6'h0B);
    // R7: window 1 dead at zero, live with limit only
    probe("R7", 32'h0000_0000, 1'b1, 1'b0);
    wr("R7", 6'h0E, 4'hF, 32'h0000_0004);
    probe("R7", 32'h0000_0000, 1'b1, 1'b0);
    probe("R7", 32'h0000_0007, 1'b1, 1'b0);
    probe("R7", 32'h0000_0008, 1'b1, 1'b1);
    // R9: inverted window 1
    wr("R9", 6'h0D, 4'hF, 32'h0000_0100);
    wr("R9", 6'h0E, 4'hF, 32'h0000_0010);
    rd("R9", 6'h0D);
    probe("R9", 32'h0000_0100, 1'b1, 1'b0);
    probe("R9", 32'h0000_0010, 1'b1, 1'b1);
    // R8: both windows in one page, second one above the first
    wr("R8", 6'h0D, 4'hF, 32'h1234_5700);
    wr("R8", 6'h0E, 4'h3, 32'hFFFF_57FC);
    probe("R8", 32'h1234_57FF, 1'b1, 1'b0);
    probe("R8", 32'h1234_5800, 1'b1, 1'b1);
    probe("R8", 32'h1234_5679, 1'b1, 1'b0);
    // R1: reset again clears everything
    rst_n = 1'b0;
    @(posedge clk);
    for (int w = 0; w < 2; w++) begin m_base[w] = 0; m_lim[w] = 0; end
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1", 6'h0B); rd("R1", 6'h0E);
    probe("R1", 32'h1234_5678, 1'b1, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule